// File: doc/BRIEF.md
# Seven-Slot Pixel Lane Serializer

This block turns one parallel pixel into seven bit slots on each of four single-ended data lanes, with a matching clock-lane pattern, for a flat-panel link of the seven-to-one kind. The pixel is 8 bits of red, green and blue plus horizontal sync, vertical sync and data enable. The block runs on a fast clock, and a bit-rate enable that pulses seven times per pixel period advances it. A slot sequencer steps through seven named states, `SLOT0` to `SLOT6`. Each enabled edge moves it on by one: `SLOT0`→`SLOT1`→…→`SLOT6`→`SLOT0`. Without the enable it holds its state. Reset forces `SLOT0`.

The pixel, the sync bits, the mapping selector and the mirror flag are all latched on the enabled edge that emits slot 0, so a change applies from the next pixel. The selector picks one of three packings. The 18-bit packing uses six bits per colour on three lanes and leaves the fourth lane low. The split 24-bit packing puts the top six bits of each colour on lanes 0–2 and the two low bits on lane 3. The compatible 24-bit packing keeps the 18-bit layout on lanes 0–2 and adds the two top bits of each colour on lane 3. The mirror flag sends the slots of every data lane in reverse order. The clock lane is never reversed.

Top module: `pix_lane_serializer`

## Requirements
- R1: The outputs move to the next slot only on clock edges where `bit_en` is 1, and hold their value otherwise. After the edge that emits slot 6, the next enabled edge emits slot 0. After the enabled edge that emits slot k, `lane_data` and `lane_clk` show slot k.
- R2: With `map_sel` 0 or 3 (18-bit), the slots 0..6 of each lane are: lane 0 = G0,R5,R4,R3,R2,R1,R0; lane 1 = B1,B0,G5,G4,G3,G2,G1; lane 2 = DE,VS,HS,B5,B4,B3,B2. Lane 3 is 0 in every slot.
- R3: With `map_sel` 1 (split 24-bit), the slots 0..6 of each lane are: lane 0 = G2,R7,R6,R5,R4,R3,R2; lane 1 = B3,B2,G7,G6,G5,G4,G3; lane 2 = DE,VS,HS,B7,B6,B5,B4; lane 3 = 0,B1,B0,G1,G0,R1,R0.
- R4: With `map_sel` 2 (compatible 24-bit), lanes 0–2 follow R2 using colour bits 5..0. Lane 3 carries 0,B7,B6,G7,G6,R7,R6 in slots 0..6.
- R5: In every packing, lane 2 carries data enable in slot 0, vertical sync in slot 1 and horizontal sync in slot 2. Lane 3 carries a constant 0 in slot 0.
- R6: When `mirror` is 1, every data lane sends the bit of slot 6 first and the bit of slot 0 last.
- R7: `lane_clk` sends 1,1,0,0,0,1,1 over slots 0..6, whatever the value of `mirror`.
- R8: The pixel inputs, `map_sel` and `mirror` are sampled only on the enabled edge that emits slot 0. Changes on later edges of the same pixel have no effect on its slots.
- R9: A synchronous `rst` drives `lane_data` and `lane_clk` to 0 and returns the sequencer to `SLOT0`. This holds even in the middle of a pixel and even if `bit_en` is 1. The first enabled edge after reset emits slot 0 of a newly captured pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Slot advance enable, seven per pixel |
| red | input | 8 | Red component |
| green | input | 8 | Green component |
| blue | input | 8 | Blue component |
| hsync | input | 1 | Horizontal sync |
| vsync | input | 1 | Vertical sync |
| den | input | 1 | Data enable |
| map_sel | input | 2 | Packing: 0/3 18-bit, 1 split 24-bit, 2 compatible 24-bit |
| mirror | input | 1 | Reverse slot order on data lanes |
| lane_data | output | 4 | Serial bit of each data lane |
| lane_clk | output | 1 | Clock-lane bit |

## Verification
The hardest case to reach from the ports is an input change in the middle of a pixel. That change must be ignored, while the same change made at a pixel boundary must take effect. The driver scrambles the colours, the selector and the mirror flag right after the slot-0 edge, and the scoreboard still expects the slots of the originally captured pixel. A second hard case is a reset partway through a pixel. The bench emits three slots, asserts reset with the enable still high, and then expects a fresh slot 0. Sparse enables with idle gaps test the hold behaviour.

// File: rtl/pix_ser_pkg.sv
package pix_ser_pkg;
    localparam int NUM_SLOTS = 7;
    localparam int NUM_LANES = 4;
    localparam int COLOR_W   = 8;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);

    typedef enum logic [SLOT_W-1:0] {
        SLOT0 = 3'd0, SLOT1 = 3'd1, SLOT2 = 3'd2, SLOT3 = 3'd3,
        SLOT4 = 3'd4, SLOT5 = 3'd5, SLOT6 = 3'd6
    } slot_e;

    typedef enum logic [1:0] {
        MAP_18        = 2'd0,
        MAP_24_SPLIT  = 2'd1,
        MAP_24_COMPAT = 2'd2,
        MAP_18_ALT    = 2'd3
    } map_e;

    // bit k of a lane word is the bit sent in slot k
    typedef logic [NUM_LANES-1:0][NUM_SLOTS-1:0] lane_words_t;

    localparam logic [NUM_SLOTS-1:0] CLK_PATTERN = 7'b1100011;
endpackage

// File: rtl/pix_slot_fsm.sv
module pix_slot_fsm
    import pix_ser_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  bit_en,
    output slot_e slot
);
    slot_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= SLOT0;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (bit_en) begin
            unique case (state_q)
                SLOT0:   state_d = SLOT1;
                SLOT1:   state_d = SLOT2;
                SLOT2:   state_d = SLOT3;
                SLOT3:   state_d = SLOT4;
                SLOT4:   state_d = SLOT5;
                SLOT5:   state_d = SLOT6;
                SLOT6:   state_d = SLOT0;
                default: state_d = SLOT0;
            endcase
        end
    end

    always_comb slot = state_q;
endmodule

// File: rtl/pix_lane_mapper.sv
module pix_lane_mapper
    import pix_ser_pkg::*;
(
    input  logic [COLOR_W-1:0] red,
    input  logic [COLOR_W-1:0] green,
    input  logic [COLOR_W-1:0] blue,
    input  logic               hsync,
    input  logic               vsync,
    input  logic               den,
    input  map_e               mode,
    output lane_words_t        words
);
    localparam int SIX = 6;

    logic [SIX-1:0] r6, g6, b6;
    logic           split;

    always_comb begin
        split = (mode == MAP_24_SPLIT);
        r6 = split ? red[COLOR_W-1 -: SIX]   : red[SIX-1:0];
        g6 = split ? green[COLOR_W-1 -: SIX] : green[SIX-1:0];
        b6 = split ? blue[COLOR_W-1 -: SIX]  : blue[SIX-1:0];

        words    = '0;
        words[0] = {r6[0], r6[1], r6[2], r6[3], r6[4], r6[5], g6[0]};
        words[1] = {g6[1], g6[2], g6[3], g6[4], g6[5], b6[0], b6[1]};
        words[2] = {b6[2], b6[3], b6[4], b6[5], hsync, vsync, den};
        unique case (mode)
            MAP_24_SPLIT:  words[3] = {red[0], red[1], green[0], green[1],
                                       blue[0], blue[1], 1'b0};
            MAP_24_COMPAT: words[3] = {red[6], red[7], green[6], green[7],
                                       blue[6], blue[7], 1'b0};
            default:       words[3] = '0;
        endcase
    end
endmodule

// File: rtl/pix_lane_output.sv
module pix_lane_output
    import pix_ser_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bit_en,
    input  slot_e                slot,
    input  lane_words_t          words_in,
    input  logic                 mirror,
    output logic [NUM_LANES-1:0] lane_data,
    output logic                 lane_clk
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

    lane_words_t          words_q, words_use;
    logic                 mir_q, mir_use, first;
    logic [SLOT_W-1:0]    pos;
    logic [NUM_LANES-1:0] bits_next;

    always_comb begin
        first     = (slot == SLOT0);
        words_use = first ? words_in : words_q;
        mir_use   = first ? mirror   : mir_q;
        pos       = mir_use ? (LAST - SLOT_W'(slot)) : SLOT_W'(slot);
    end

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        assign bits_next[l] = words_use[l][pos];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            words_q   <= '0;
            mir_q     <= 1'b0;
            lane_data <= '0;
            lane_clk  <= 1'b0;
        end else if (bit_en) begin
            if (first) begin
                words_q <= words_in;
                mir_q   <= mirror;
            end
            lane_data <= bits_next;
            lane_clk  <= CLK_PATTERN[slot];
        end
    end
endmodule

// File: rtl/pix_lane_serializer.sv
module pix_lane_serializer
    import pix_ser_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bit_en,
    input  logic [COLOR_W-1:0]   red,
    input  logic [COLOR_W-1:0]   green,
    input  logic [COLOR_W-1:0]   blue,
    input  logic                 hsync,
    input  logic                 vsync,
    input  logic                 den,
    input  logic [1:0]           map_sel,
    input  logic                 mirror,
    output logic [NUM_LANES-1:0] lane_data,
    output logic                 lane_clk
);
    slot_e       slot_cur;
    map_e        mode;
    lane_words_t words;

    always_comb mode = map_e'(map_sel);

    pix_slot_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .bit_en (bit_en),
        .slot   (slot_cur)
    );

    pix_lane_mapper u_map (
        .red   (red),
        .green (green),
        .blue  (blue),
        .hsync (hsync),
        .vsync (vsync),
        .den   (den),
        .mode  (mode),
        .words (words)
    );

    pix_lane_output u_out (
        .clk       (clk),
        .rst       (rst),
        .bit_en    (bit_en),
        .slot      (slot_cur),
        .words_in  (words),
        .mirror    (mirror),
        .lane_data (lane_data),
        .lane_clk  (lane_clk)
    );
endmodule

// File: rtl/pix_ser_chk.sv
module pix_ser_chk
    import pix_ser_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 bit_en,
    input logic [1:0]           map_sel,
    input logic                 mirror,
    input slot_e                slot,
    input logic [NUM_LANES-1:0] lane_data,
    input logic                 lane_clk
);
    // R9
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (lane_data == '0 && !lane_clk && slot == SLOT0));

    // R1
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> ($stable(lane_data) && $stable(lane_clk)));

    // R1
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_en && slot == SLOT6) |=> slot == SLOT0);

    // R7
    clk_high_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_en && slot == SLOT0) |=> lane_clk);

    // R7
    clk_low_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_en && slot == SLOT3) |=> !lane_clk);

    // R2
    lane3_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_en && slot == SLOT0 && map_sel[0] == map_sel[1]) |=> !lane_data[3]);

    // R5
    lane3_lead_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_en && slot == SLOT0 && !mirror) |=> !lane_data[3]);
endmodule

bind pix_lane_serializer pix_ser_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .map_sel   (map_sel),
    .mirror    (mirror),
    .slot      (slot_cur),
    .lane_data (lane_data),
    .lane_clk  (lane_clk)
);

// File: tb/pix_lane_serializer_test.sv
module pix_lane_serializer_test;
    logic       clk = 0, rst = 1, bit_en = 0;
    logic [7:0] red = 0, green = 0, blue = 0;
    logic       hsync = 0, vsync = 0, den = 0, mirror = 0;
    logic [1:0] map_sel = 0;
    logic [3:0] lane_data;
    logic       lane_clk;

    int total = 0, bad = 0, cycles = 0;
    bit done = 0;

    typedef struct {
        logic [3:0] d;
        logic       c;
        string      tag;
    } item_t;
    item_t q[$];

    pix_lane_serializer uut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .red(red), .green(green),
        .blue(blue), .hsync(hsync), .vsync(vsync), .den(den),
        .map_sel(map_sel), .mirror(mirror), .lane_data(lane_data),
        .lane_clk(lane_clk)
    );

    always #10 clk = ~clk;

    function automatic logic [3:0] exp_lanes(int p, logic [7:0] r, logic [7:0] g,
                                             logic [7:0] b, logic hs, logic vs,
                                             logic de, logic [1:0] md, logic mir);
        int k;
        logic [3:0] o;
        k = mir ? 6 - p : p;
        o = '0;
        if (md == 2'd1) begin
            if (k == 0) o[0] = g[2]; else o[0] = r[8-k];
            if (k == 0) o[1] = b[3]; else if (k == 1) o[1] = b[2]; else o[1] = g[9-k];
            if (k == 0) o[2] = de; else if (k == 1) o[2] = vs;
            else if (k == 2) o[2] = hs; else o[2] = b[10-k];
            case (k)
                1: o[3] = b[1]; 2: o[3] = b[0]; 3: o[3] = g[1];
                4: o[3] = g[0]; 5: o[3] = r[1]; 6: o[3] = r[0];
                default: o[3] = 1'b0;
            endcase
        end else begin
            if (k == 0) o[0] = g[0]; else o[0] = r[6-k];
            if (k == 0) o[1] = b[1]; else if (k == 1) o[1] = b[0]; else o[1] = g[7-k];
            if (k == 0) o[2] = de; else if (k == 1) o[2] = vs;
            else if (k == 2) o[2] = hs; else o[2] = b[8-k];
            if (md == 2'd2) begin
                case (k)
                    1: o[3] = b[7]; 2: o[3] = b[6]; 3: o[3] = g[7];
                    4: o[3] = g[6]; 5: o[3] = r[7]; 6: o[3] = r[6];
                    default: o[3] = 1'b0;
                endcase
            end
        end
        return o;
    endfunction

    function automatic logic clk_exp(int p);
        return (p <= 1) || (p >= 5);
    endfunction

    task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // scoreboard driver: one expected item per enabled edge
    task automatic send_pixel(logic [7:0] r, logic [7:0] g, logic [7:0] b,
                              logic hs, logic vs, logic de, logic [1:0] md,
                              logic mir, int gap, int nslots, bit scramble,
                              string tag);
        for (int p = 0; p < nslots; p++) begin
            @(negedge clk);
            if (p == 0) begin
                red = r; green = g; blue = b; hsync = hs; vsync = vs; den = de;
                map_sel = md; mirror = mir;
            end else if (scramble) begin
                red = 8'($urandom); green = 8'($urandom); blue = 8'($urandom);
                hsync = ~hsync; vsync = ~vsync; den = ~den;
                map_sel = 2'($urandom); mirror = ~mirror;
            end
            bit_en = 1'b1;
            q.push_back('{exp_lanes(p, r, g, b, hs, vs, de, md, mir), clk_exp(p), tag});
            for (int i = 0; i < gap; i++) begin
                @(negedge clk);
                bit_en = 1'b0;
            end
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_en = 1'b0;
        end
    endtask

    task automatic do_reset(bit en_during);
        @(negedge clk);
        rst = 1'b1;
        bit_en = en_during;
        @(negedge clk);
        check("R9 reset", {lane_data, lane_clk}, 5'b0);
        total++;
        if (q.size() != 0) begin
            bad++;
            $display("FAIL R9 pending=%0d expected=0", q.size());
        end
        rst = 1'b0;
        bit_en = 1'b0;
    endtask

    // monitor
    logic took = 0, held = 0;
    logic [4:0] prev = '0;
    always @(posedge clk) begin
        took <= bit_en & ~rst;
        held <= ~bit_en & ~rst;
    end

    always @(negedge clk) begin
        if (took) begin
            if (q.size() == 0) begin
                total++; bad++;
                $display("FAIL R1 actual=unexpected_slot expected=none");
            end else begin
                item_t it;
                it = q.pop_front();
                check(it.tag, {1'b0, lane_data}, {1'b0, it.d});
                check("R7 clock lane", {4'b0, lane_clk}, {4'b0, it.c});
            end
        end else if (held) begin
            check("R1 hold", {lane_data, lane_clk}, prev);
        end
        prev <= {lane_data, lane_clk};
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset(1'b0);
        // R2: 18-bit packing, incl. selector value 3
        send_pixel(8'h3F, 8'h00, 8'h00, 0, 0, 0, 2'd0, 0, 0, 7, 0, "R2 red");
        send_pixel(8'h00, 8'h2A, 8'h15, 1, 0, 1, 2'd0, 0, 0, 7, 0, "R2 gb");
        send_pixel(8'hC5, 8'hFF, 8'hFF, 0, 1, 0, 2'd3, 0, 0, 7, 0, "R2 alt");
        // R3: split 24-bit
        send_pixel(8'hA5, 8'h3C, 8'hC3, 1, 1, 1, 2'd1, 0, 0, 7, 0, "R3 a");
        send_pixel(8'h03, 8'h0C, 8'hF0, 0, 0, 0, 2'd1, 0, 0, 7, 0, "R3 b");
        // R4: compatible 24-bit
        send_pixel(8'hC0, 8'h40, 8'h80, 0, 0, 1, 2'd2, 0, 0, 7, 0, "R4 a");
        send_pixel(8'h5A, 8'h96, 8'h69, 1, 0, 0, 2'd2, 0, 0, 7, 0, "R4 b");
        // R5: control slots walked one at a time
        send_pixel(8'h00, 8'h00, 8'h00, 1, 0, 0, 2'd1, 0, 0, 7, 0, "R5 hs");
        send_pixel(8'h00, 8'h00, 8'h00, 0, 1, 0, 2'd2, 0, 0, 7, 0, "R5 vs");
        send_pixel(8'hFF, 8'hFF, 8'hFF, 0, 0, 1, 2'd0, 0, 0, 7, 0, "R5 de");
        // R6: mirror in each packing
        send_pixel(8'h35, 8'h1B, 8'h2E, 1, 0, 1, 2'd0, 1, 0, 7, 0, "R6 m18");
        send_pixel(8'hA5, 8'h3C, 8'hC3, 0, 1, 1, 2'd1, 1, 0, 7, 0, "R6 split");
        send_pixel(8'hC1, 8'h42, 8'h84, 1, 1, 0, 2'd2, 1, 0, 7, 0, "R6 compat");
        // R1: sparse enable with idle gaps
        send_pixel(8'h6D, 8'hB2, 8'h59, 1, 0, 1, 2'd1, 0, 2, 7, 0, "R1 gap2");
        send_pixel(8'h92, 8'h4D, 8'hA6, 0, 1, 0, 2'd2, 1, 3, 7, 0, "R1 gap3");
        // R8: inputs scrambled after slot 0
        send_pixel(8'h81, 8'h7E, 8'h18, 1, 0, 1, 2'd1, 0, 0, 7, 1, "R8 split");
        send_pixel(8'h24, 8'hDB, 8'hE7, 0, 1, 0, 2'd0, 1, 1, 7, 1, "R8 mir");
        send_pixel(8'hF0, 8'h0F, 8'h99, 1, 1, 1, 2'd2, 0, 0, 7, 1, "R8 compat");
        idle(3);
        // R9: reset mid-pixel with enable held high, then a fresh slot 0
        send_pixel(8'hFF, 8'hFF, 8'hFF, 1, 1, 1, 2'd1, 0, 0, 3, 0, "R9 partial");
        do_reset(1'b1);
        send_pixel(8'h13, 8'h57, 8'h9B, 0, 1, 1, 2'd1, 0, 0, 7, 0, "R9 restart");
        idle(4);
        total++;
        if (q.size() != 0) begin
            bad++;
            $display("FAIL R1 pending=%0d expected=0", q.size());
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule